// File: doc/BRIEF.md
# Fixed-Point PI Current Regulator

This block closes a digital current loop once per modulation period. A one-cycle strobe at the start of each period launches one iteration. The block takes an unsigned converter code that carries a bipolar current offset by half of full scale, and recentres it to a signed fraction. It subtracts that measurement from the current reference to form the error. It then adds a proportional term to a forward-accumulated integral term and returns a duty word for the modulator.

All internal values are signed fractions with one sign bit and `DW-1` fractional bits, so full scale stands for unity. The two gains may exceed unity: each carries `GI` integer bits, and every product is shifted to return it to the internal fraction before the terms are summed. The integral accumulator clamps at the signed fractional limits. The output sum clamps to the range from zero to one-minus-LSB and is then cut to the modulator width by truncation. A done strobe marks the cycle in which the new duty word appears.

Top module: `pi_current_reg`

## Requirements
- R1: The measured current equals (code − 2^(ADC_W−1)) · 2^(DW−ADC_W) as a signed DW-bit value. Code 2^(ADC_W−1) is therefore zero, code 0 is −1 and code 2^ADC_W−1 is just below +1.
- R2: The error equals reference minus measurement, clamped to the signed range [−2^(DW−1), 2^(DW−1)−1].
- R3: Each gain word is a signed DW-bit value scaled by 2^−(DW−1−GI). Each product term equals floor(error · gain / 2^(DW−1−GI)), with the floor taken toward minus infinity.
- R4: The integral is forward-accumulated. In each iteration the new accumulator value is the old value plus the integral product, and that new value enters the same iteration's output sum.
- R5: The accumulator clamps to [−2^(DW−1), 2^(DW−1)−1]. At a limit it does not move further in the direction of saturation, and it leaves the limit as soon as the term changes sign.
- R6: The output sum (proportional term plus new accumulator) is clamped to [0, 2^(DW−1)−1] before it is reduced.
- R7: The duty word equals the clamped sum shifted right by DW−1−PWM_W bits, with the dropped bits truncated.
- R8: A start strobe sampled on a rising edge produces a done pulse exactly one clock wide on the second following rising edge. The duty word is updated on that same edge.
- R9: While reset is low, duty is 0, done is 0 and the accumulator is 0.
- R10: Without a start strobe, duty and the accumulator hold their values whatever the other inputs do, and done stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Period-start strobe, one cycle wide |
| adc_code_i | input | ADC_W | Unsigned converter code, half scale is zero current |
| iref_i | input | DW | Signed fractional current reference |
| kp_i | input | DW | Proportional gain, GI integer bits |
| ki_i | input | DW | Integral gain times sample period, GI integer bits |
| duty_o | output | PWM_W | Duty word for the modulator |
| done_o | output | 1 | One-cycle pulse with each new duty word |

## Verification
Accumulator clamping and output clamping can occur in the same iteration. The bench provokes both by driving a full-scale positive error with a near-maximal integral gain for several periods, so the accumulator hits its upper limit while the sum pins the duty at its ceiling. It then reverses the error to full negative so that both clamps engage at the lower end. Each duty word is compared against a running arithmetic model of the accumulator. Recovery from the limit therefore shows whether the accumulator stayed exactly at its bound or wound up past it.

// File: rtl/pi_pkg.sv
package pi_pkg;
   // width of a rescaled product term
   function automatic int term_width(input int dw, input int gi);
      return dw + 1 + gi;
   endfunction

   // right shift that returns a product to the internal fraction
   function automatic int prod_shift(input int dw, input int gi);
      return dw - 1 - gi;
   endfunction

   // right shift from the internal fraction to the duty word
   function automatic int duty_shift(input int dw, input int pw);
      return dw - 1 - pw;
   endfunction
endpackage

// File: rtl/pi_adc_recenter.sv
module pi_adc_recenter #(
   parameter int ADC_W = 12,
   parameter int DW    = 16
) (
   input  logic [ADC_W-1:0]       code,
   output logic signed [DW-1:0]   meas
);
   // subtracting half scale equals inverting the code's top bit
   generate
      if (DW == ADC_W) begin : g_same
         assign meas = {~code[ADC_W-1], code[ADC_W-2:0]};
      end else begin : g_pad
         assign meas = {~code[ADC_W-1], code[ADC_W-2:0], {(DW-ADC_W){1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/pi_frac_mul.sv
module pi_frac_mul #(
   parameter int DW = 16,
   parameter int GI = 2,
   localparam int MW = pi_pkg::term_width(DW, GI),
   localparam int SH = pi_pkg::prod_shift(DW, GI)
) (
   input  logic signed [DW-1:0] a,
   input  logic signed [DW-1:0] b,
   output logic signed [MW-1:0] q
);
   logic signed [2*DW-1:0] prod;

   always_comb begin
      prod = $signed({{DW{a[DW-1]}}, a}) * $signed({{DW{b[DW-1]}}, b});
      q    = MW'(prod >>> SH);
   end
endmodule

// File: rtl/pi_sat.sv
module pi_sat #(
   parameter int     IW = 18,
   parameter int     OW = 16,
   parameter longint LO = -32768,
   parameter longint HI = 32767
) (
   input  logic signed [IW-1:0] x,
   output logic signed [OW-1:0] y
);
   localparam logic signed [IW-1:0] LO_W = IW'(LO);
   localparam logic signed [IW-1:0] HI_W = IW'(HI);

   generate
      if (OW > IW) begin : g_bad_width
         $error("pi_sat: output wider than input");
      end
   endgenerate

   always_comb begin
      if (x < LO_W)      y = OW'(LO_W);
      else if (x > HI_W) y = OW'(HI_W);
      else               y = OW'(x);
   end
endmodule

// File: rtl/pi_current_reg.sv
module pi_current_reg #(
   parameter int DW    = 16,
   parameter int ADC_W = 12,
   parameter int PWM_W = 10,
   parameter int GI    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADC_W-1:0]  adc_code_i,
   input  logic [DW-1:0]     iref_i,
   input  logic [DW-1:0]     kp_i,
   input  logic [DW-1:0]     ki_i,
   output logic [PWM_W-1:0]  duty_o,
   output logic              done_o
);
   localparam int     MW     = pi_pkg::term_width(DW, GI);
   localparam int     DSH    = pi_pkg::duty_shift(DW, PWM_W);
   localparam longint FR_MAX = (longint'(1) << (DW-1)) - 1;
   localparam longint FR_MIN = -(longint'(1) << (DW-1));

   generate
      if (ADC_W < 2 || ADC_W > DW) begin : g_bad_adc
         $error("pi_current_reg: ADC_W must lie in 2..DW");
      end
      if (PWM_W < 1 || PWM_W > DW-1) begin : g_bad_pwm
         $error("pi_current_reg: PWM_W must lie in 1..DW-1");
      end
      if (GI < 0 || GI > DW-2) begin : g_bad_gi
         $error("pi_current_reg: GI must lie in 0..DW-2");
      end
   endgenerate

   // stage 1: recentre and form the error
   logic signed [DW-1:0] meas;
   logic signed [DW:0]   diff;
   logic signed [DW-1:0] err_n, err_q;
   logic                 v1_q;

   pi_adc_recenter #(.ADC_W(ADC_W), .DW(DW)) u_recenter (
      .code (adc_code_i),
      .meas (meas)
   );

   assign diff = {iref_i[DW-1], iref_i} - {meas[DW-1], meas};

   pi_sat #(.IW(DW+1), .OW(DW), .LO(FR_MIN), .HI(FR_MAX)) u_err_sat (
      .x (diff),
      .y (err_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q <= '0;
         v1_q  <= 1'b0;
      end else begin
         v1_q <= start_i;
         if (start_i) err_q <= err_n;
      end
   end

   // stage 2: products, integral, output sum
   logic signed [MW-1:0] p_term, i_term;
   logic signed [MW:0]   acc_sum, out_sum;
   logic signed [DW-1:0] acc_n, acc_q, u_sat;

   pi_frac_mul #(.DW(DW), .GI(GI)) u_mul_p (
      .a (err_q),
      .b ($signed(kp_i)),
      .q (p_term)
   );

   pi_frac_mul #(.DW(DW), .GI(GI)) u_mul_i (
      .a (err_q),
      .b ($signed(ki_i)),
      .q (i_term)
   );

   assign acc_sum = {{(MW+1-DW){acc_q[DW-1]}}, acc_q} + {i_term[MW-1], i_term};

   pi_sat #(.IW(MW+1), .OW(DW), .LO(FR_MIN), .HI(FR_MAX)) u_acc_sat (
      .x (acc_sum),
      .y (acc_n)
   );

   assign out_sum = {p_term[MW-1], p_term} + {{(MW+1-DW){acc_n[DW-1]}}, acc_n};

   pi_sat #(.IW(MW+1), .OW(DW), .LO(0), .HI(FR_MAX)) u_out_sat (
      .x (out_sum),
      .y (u_sat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         duty_o <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= v1_q;
         if (v1_q) begin
            acc_q  <= acc_n;
            duty_o <= PWM_W'(u_sat >> DSH);
         end
      end
   end
endmodule

// File: rtl/pi_current_reg_chk.sv
module pi_current_reg_chk #(
   parameter int DW    = 16,
   parameter int PWM_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             done_o,
   input logic [PWM_W-1:0] duty_o,
   input logic [DW-1:0]    acc_q
);
   // R8: done follows start by two edges, and only then
   assert_done_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> ##2 done_o);
   assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(start_i, 2));

   // R10: no iteration, no change
   assert_duty_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(duty_o));
   assert_acc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(acc_q));

   // R9: reset clears outputs and integral
   assert_reset_state_R9: assert property (@(posedge clk)
      !rst_n |=> (duty_o == '0 && !done_o && acc_q == '0));
endmodule

bind pi_current_reg pi_current_reg_chk #(.DW(DW), .PWM_W(PWM_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .done_o  (done_o),
   .duty_o  (duty_o),
   .acc_q   (acc_q)
);

// File: tb/pi_current_reg_test.sv
module pi_current_reg_test;
   localparam int DW = 12, ADC_W = 8, PWM_W = 6, GI = 1;
   localparam longint FMAX = 2047, FMIN = -2048;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [ADC_W-1:0]  adc_code_i = '0;
   logic [DW-1:0]     iref_i = '0, kp_i = '0, ki_i = '0;
   logic [PWM_W-1:0]  duty_o;
   logic              done_o;

   int errors = 0, checks = 0;
   longint m_acc = 0;
   longint last_duty = 0;

   always #5 clk = ~clk;

   pi_current_reg #(.DW(DW), .ADC_W(ADC_W), .PWM_W(PWM_W), .GI(GI)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .adc_code_i(adc_code_i),
      .iref_i(iref_i), .kp_i(kp_i), .ki_i(ki_i), .duty_o(duty_o), .done_o(done_o)
   );

   function automatic longint sat(input longint v, input longint lo, input longint hi);
      return (v < lo) ? lo : ((v > hi) ? hi : v);
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one regulator iteration against the arithmetic model
   task automatic run_iter(input int code, input longint iref, input longint kp,
                           input longint ki, input string req);
      longint meas, err, pt, it, u, dexp;
      meas  = (longint'(code) - 128) * 16;            // R1
      err   = sat(iref - meas, FMIN, FMAX);          // R2
      pt    = (err * kp) >>> 10;                     // R3
      it    = (err * ki) >>> 10;
      m_acc = sat(m_acc + it, FMIN, FMAX);           // R4, R5
      u     = sat(pt + m_acc, 0, FMAX);              // R6
      dexp  = u >> 5;                                // R7
      @(negedge clk);
      adc_code_i = ADC_W'(code);
      iref_i = DW'(iref); kp_i = DW'(kp); ki_i = DW'(ki);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check("R8 done low one edge after start", longint'(done_o), 0);
      @(negedge clk);
      check("R8 done high two edges after start", longint'(done_o), 1);
      check(req, longint'(duty_o), dexp);
      last_duty = dexp;
   endtask

   initial begin
      #1_500_000;
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      // R9 reset state
      repeat (3) @(negedge clk);
      check("R9 duty in reset", longint'(duty_o), 0);
      check("R9 done in reset", longint'(done_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 duty after reset", longint'(duty_o), 0);

      // R1 R3 R7: proportional only, full code sweep
      for (int c = 0; c < 256; c++) run_iter(c, 0, 512, 0, "R1 R3 R7 prop sweep");
      // R2 high clamp of the error
      for (int c = 0; c < 256; c++) run_iter(c, 1000, 1792, 0, "R2 R3 error high clamp");
      // R2 low clamp, negative gain, R6 low clamp
      for (int c = 0; c < 256; c++) run_iter(c, -1500, -600, 0, "R2 R6 negative gain");

      // R4 forward integral build-up
      for (int k = 0; k < 30; k++) run_iter(100, 0, 0, 40, "R4 integral step");
      // R5 and R6 together: wind up to the upper limit
      for (int k = 0; k < 10; k++) run_iter(0, 2047, 300, 2047, "R5 R6 upper windup");
      // R5 leave the limit at once, then clamp low
      for (int k = 0; k < 4; k++) run_iter(255, -2048, 0, 2047, "R5 R6 lower clamp");
      for (int k = 0; k < 20; k++) run_iter(40, 0, 1024, 300, "R5 recovery");

      // R10: idle cycles with moving inputs
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         adc_code_i = ADC_W'(k * 13);
         iref_i = DW'(k * 97);
         ki_i = DW'(1500);
         check("R10 done idle", longint'(done_o), 0);
         check("R10 duty held", longint'(duty_o), last_duty);
      end
      run_iter(128, 900, 700, 100, "R10 accumulator held");

      // mixed sweep
      for (int k = 0; k < 64; k++)
         run_iter((k * 37) % 256, longint'(k) * 64 - 2048, 900, 200, "R4 R6 mixed sweep");

      @(negedge clk);
      check("R8 done single cycle", longint'(done_o), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule